// File: doc/BRIEF.md
# DMA channel address and count register file

This block holds the programmable registers of a four-channel DMA engine and makes them reachable through a byte-wide I/O port. Every channel has a 16-bit start address and a 16-bit transfer count, which software loads, and a live copy of each that moves as the engine transfers data. A port offset selects a channel and one of its two registers. Each 16-bit value is reached one byte at a time through a single low/high byte pointer that all channels share.

Loading the high byte of either register restarts the channel. The live address is reloaded from the programmed start address and the progress counter is cleared. A read of the count register returns how much of the programmed count is still left. A read of the address register returns the live address. The transfer engine, which sits outside this block, reports each completed unit through a step input. That input moves the live address up or down and adds to the progress count.

A parameter `SHIFT` chooses the variant. With `SHIFT` = 0 the controller moves bytes. With `SHIFT` = 1 it moves 16-bit words: the port window is twice as wide, the live address and the progress are kept in byte units, and both are scaled by two when they are loaded and when they are read.

Top module: `dma_chan_regfile`

## Requirements
- R1: After reset every start address, count, live address and progress value is zero and the byte pointer is low, so every channel register reads 0x00.
- R2: The port index is offset bits [SHIFT+3:SHIFT]. Index bits [2:1] pick the channel, and index bit 0 picks the address (0) or the count (1). Offset bits below SHIFT are ignored. An access with index bit 3 set changes no register and does not move the byte pointer.
- R3: The byte pointer flips after every read or write of a channel register. A pulse on `ptr_clear` forces it low on the next cycle, and the clear overrides an access made in the same cycle.
- R4: A write with the pointer low replaces only bits [7:0] of the selected start register. The live address and the progress are not touched.
- R5: A write with the pointer high replaces bits [15:8] of the selected start register. It also sets that channel's live address to (new start address << SHIFT) and clears its progress to zero.
- R6: An address read returns bits [SHIFT+7:SHIFT] of the live address when the pointer is low, and bits [SHIFT+15:SHIFT+8] when it is high.
- R7: A count read returns the same byte lanes, taken from ((start count << SHIFT) − progress) modulo 2^(16+SHIFT).
- R8: A step on `step_valid` for channel `step_chan` adds 2^SHIFT to that channel's progress. It also moves that channel's live address by 2^SHIFT, down when `step_down` is 1 and up otherwise. No other channel changes.
- R9: When a high-byte write restarts a channel in the same cycle as a step for that channel, the restart wins. A step for a different channel in that cycle still applies.
- R10: The live address wraps modulo 2^(16+SHIFT) in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_wr | input | 1 | Write strobe for the port |
| port_rd | input | 1 | Read strobe for the port |
| port_ofs | input | 4+SHIFT | Port offset |
| port_wdata | input | 8 | Write data byte |
| port_rdata | output | 8 | Read data byte, valid in the cycle of `port_rd` |
| ptr_clear | input | 1 | Forces the byte pointer low |
| step_valid | input | 1 | One transfer unit completed |
| step_chan | input | 2 | Channel that completed the unit |
| step_down | input | 1 | Direction of the address step: 1 down, 0 up |

## Verification
The assertions assume that `port_wr` and `port_rd` are never high in the same cycle, and that strobes only change once reset has been released through the internal synchroniser. Under those conditions they check how the byte pointer moves, that a restart clears progress, that a step adds exactly one unit, and that idle cycles leave the state alone. The stimulus drives at most one port strobe per cycle. It changes inputs one time unit after a rising edge and waits several cycles after reset before the first access. Two copies of the block, one for each `SHIFT` value, receive the same index, and the word variant is given a set bit in its ignored offset bit.

// File: rtl/dma_chregs_pkg.sv
package dma_chregs_pkg;
  localparam int NUM_CHAN = 4;
  localparam int CHAN_W   = 2;
  localparam int IDX_W    = 4;

  typedef enum logic {
    SEL_ADDR  = 1'b0,
    SEL_COUNT = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic              hit;
    logic [CHAN_W-1:0] chan;
    reg_sel_e          sel;
  } port_dec_t;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_chregs_pkg::*;
#(
  parameter int SHIFT = 0,
  localparam int OFS_W = IDX_W + SHIFT
) (
  input  logic [OFS_W-1:0] ofs,
  output port_dec_t        dec
);
  logic [IDX_W-1:0] idx;
  logic             unused_ofs;

  assign idx        = ofs[SHIFT +: IDX_W];
  assign unused_ofs = ^ofs;

  always_comb begin
    dec.hit  = ~idx[IDX_W-1];
    dec.chan = idx[CHAN_W:1];
    dec.sel  = reg_sel_e'(idx[0]);
  end
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  input  logic clear,
  output logic ptr_hi
);
  logic ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clear)       ptr_d = 1'b0;
    else if (access) ptr_d = ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= 1'b0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_hi = ptr_q;
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_chregs_pkg::*;
#(
  parameter int SHIFT  = 0,
  parameter int DATA_W = 8,
  localparam int REG_W = 2 * DATA_W,
  localparam int CUR_W = REG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_this,
  input  reg_sel_e          wr_sel,
  input  logic              ptr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step_this,
  input  logic              step_down,
  output logic [CUR_W-1:0]  cur_addr,
  output logic [REG_W-1:0]  base_count,
  output logic [CUR_W-1:0]  progress
);
  localparam logic [CUR_W-1:0] STEP = CUR_W'(1 << SHIFT);

  logic [REG_W-1:0] base_addr_q, base_addr_d;
  logic [REG_W-1:0] base_cnt_q,  base_cnt_d;
  logic [CUR_W-1:0] cur_q, cur_d;
  logic [CUR_W-1:0] prog_q, prog_d;
  logic             reload;
  logic             upd_en;

  function automatic logic [REG_W-1:0] merge_byte(
    input logic [REG_W-1:0]  old,
    input logic [DATA_W-1:0] data,
    input logic              hi
  );
    if (hi) return {data, old[DATA_W-1:0]};
    else    return {old[REG_W-1:DATA_W], data};
  endfunction

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    if (wr_this && wr_sel == SEL_ADDR)  base_addr_d = merge_byte(base_addr_q, wdata, ptr_hi);
    if (wr_this && wr_sel == SEL_COUNT) base_cnt_d  = merge_byte(base_cnt_q,  wdata, ptr_hi);

    reload = wr_this && ptr_hi;
    upd_en = wr_this || step_this;

    cur_d  = cur_q;
    prog_d = prog_q;
    if (reload) begin
      cur_d  = CUR_W'(base_addr_d) << SHIFT;
      prog_d = '0;
    end else if (step_this) begin
      cur_d  = step_down ? (cur_q - STEP) : (cur_q + STEP);
      prog_d = prog_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_q       <= '0;
      prog_q      <= '0;
    end else if (upd_en) begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      cur_q       <= cur_d;
      prog_q      <= prog_d;
    end
  end

  assign cur_addr   = cur_q;
  assign base_count = base_cnt_q;
  assign progress   = prog_q;
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
  import dma_chregs_pkg::*;
#(
  parameter int SHIFT  = 0,
  parameter int DATA_W = 8,
  localparam int REG_W = 2 * DATA_W,
  localparam int CUR_W = REG_W + SHIFT,
  localparam int OFS_W = IDX_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_wr,
  input  logic              port_rd,
  input  logic [OFS_W-1:0]  port_ofs,
  input  logic [DATA_W-1:0] port_wdata,
  output logic [DATA_W-1:0] port_rdata,
  input  logic              ptr_clear,
  input  logic              step_valid,
  input  logic [CHAN_W-1:0] step_chan,
  input  logic              step_down
);
  logic                      rst_sync_n;
  port_dec_t                 dec;
  logic                      ptr_hi;
  logic                      chan_access;
  logic [NUM_CHAN*CUR_W-1:0] cur_flat;
  logic [NUM_CHAN*CUR_W-1:0] prog_flat;
  logic [NUM_CHAN*REG_W-1:0] bcnt_flat;
  logic [CUR_W-1:0]          sel_val;
  logic [CUR_W-1:0]          sel_shifted;

  dma_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_port_decode #(.SHIFT(SHIFT)) u_decode (
    .ofs (port_ofs),
    .dec (dec)
  );

  assign chan_access = dec.hit && (port_wr || port_rd);

  dma_byte_ptr u_byte_ptr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .access (chan_access),
    .clear  (ptr_clear),
    .ptr_hi (ptr_hi)
  );

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    logic wr_this;
    logic step_this;
    assign wr_this   = port_wr && dec.hit && (dec.chan == CHAN_W'(ch));
    assign step_this = step_valid && (step_chan == CHAN_W'(ch));

    dma_chan_slot #(.SHIFT(SHIFT), .DATA_W(DATA_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_this    (wr_this),
      .wr_sel     (dec.sel),
      .ptr_hi     (ptr_hi),
      .wdata      (port_wdata),
      .step_this  (step_this),
      .step_down  (step_down),
      .cur_addr   (cur_flat[ch*CUR_W +: CUR_W]),
      .base_count (bcnt_flat[ch*REG_W +: REG_W]),
      .progress   (prog_flat[ch*CUR_W +: CUR_W])
    );
  end

  always_comb begin
    if (dec.sel == SEL_COUNT)
      sel_val = (CUR_W'(bcnt_flat[dec.chan*REG_W +: REG_W]) << SHIFT)
                - prog_flat[dec.chan*CUR_W +: CUR_W];
    else
      sel_val = cur_flat[dec.chan*CUR_W +: CUR_W];
    sel_shifted = sel_val >> (SHIFT + (ptr_hi ? DATA_W : 0));
    port_rdata  = dec.hit ? sel_shifted[DATA_W-1:0] : '0;
  end
endmodule

// File: rtl/dma_chan_regfile_sva.sv
module dma_chan_regfile_sva
  import dma_chregs_pkg::*;
#(
  parameter int SHIFT  = 0,
  parameter int DATA_W = 8,
  localparam int REG_W = 2 * DATA_W,
  localparam int CUR_W = REG_W + SHIFT,
  localparam int OFS_W = IDX_W + SHIFT
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      port_wr,
  input logic                      port_rd,
  input logic [OFS_W-1:0]          port_ofs,
  input logic                      ptr_clear,
  input logic                      step_valid,
  input logic [CHAN_W-1:0]         step_chan,
  input logic                      ptr_hi,
  input logic [NUM_CHAN*CUR_W-1:0] cur_flat,
  input logic [NUM_CHAN*CUR_W-1:0] prog_flat,
  input logic [NUM_CHAN*REG_W-1:0] bcnt_flat
);
  localparam logic [CUR_W-1:0] STEP = CUR_W'(1 << SHIFT);

  logic [IDX_W-1:0]  c_idx;
  logic [CHAN_W-1:0] c_chan;
  logic              c_acc;
  logic              c_restart;
  logic              unused_c;

  assign c_idx     = port_ofs[SHIFT +: IDX_W];
  assign c_chan    = c_idx[CHAN_W:1];
  assign c_acc     = (port_wr || port_rd) && !c_idx[IDX_W-1];
  assign c_restart = port_wr && c_acc && ptr_hi;
  assign unused_c  = ^port_ofs;

  function automatic logic [CUR_W-1:0] prog_of(input logic [CHAN_W-1:0] ch);
    return prog_flat[ch*CUR_W +: CUR_W];
  endfunction

  a_r3_ptr_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && !ptr_clear) |=> (ptr_hi != $past(ptr_hi)));

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clear |=> !ptr_hi);

  a_r3_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_acc && !ptr_clear) |=> $stable(ptr_hi));

  a_r2_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_acc && !step_valid) |=> ($stable(cur_flat) && $stable(prog_flat) && $stable(bcnt_flat)));

  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    c_restart |=> (prog_of($past(c_chan)) == '0));

  a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !(c_restart && c_chan == step_chan))
      |=> (prog_of($past(step_chan)) == $past(prog_of(step_chan)) + STEP));
endmodule

bind dma_chan_regfile dma_chan_regfile_sva #(.SHIFT(SHIFT), .DATA_W(DATA_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .port_wr    (port_wr),
  .port_rd    (port_rd),
  .port_ofs   (port_ofs),
  .ptr_clear  (ptr_clear),
  .step_valid (step_valid),
  .step_chan  (step_chan),
  .ptr_hi     (ptr_hi),
  .cur_flat   (cur_flat),
  .prog_flat  (prog_flat),
  .bcnt_flat  (bcnt_flat)
);

// File: tb/dma_chan_regfile_bench.sv
`timescale 1ns/1ps
module dma_chan_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_wr = 1'b0, port_rd = 1'b0, ptr_clear = 1'b0;
  logic [3:0] ofs0 = '0;
  logic [4:0] ofs1 = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata0, rdata1;
  logic       step_valid = 1'b0, step_down = 1'b0;
  logic [1:0] step_chan = '0;

  always #4 clk = ~clk;

  dma_chan_regfile #(.SHIFT(0)) u_dma_chan_regfile (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_rd(port_rd),
    .port_ofs(ofs0), .port_wdata(wdata), .port_rdata(rdata0),
    .ptr_clear(ptr_clear), .step_valid(step_valid), .step_chan(step_chan),
    .step_down(step_down));

  dma_chan_regfile #(.SHIFT(1)) u_dma_chan_regfile_w16 (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_rd(port_rd),
    .port_ofs(ofs1), .port_wdata(wdata), .port_rdata(rdata1),
    .ptr_clear(ptr_clear), .step_valid(step_valid), .step_chan(step_chan),
    .step_down(step_down));

  typedef struct {
    logic [7:0] e0;
    logic [7:0] e1;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  int m_ba[4], m_bc[4];
  int m_cur[2][4], m_prg[2][4];
  bit m_ptr;

  function automatic logic [7:0] exp_byte(int s, int idx);
    int ch, v, mask;
    mask = (1 << (16 + s)) - 1;
    ch = (idx >> 1) & 3;
    if (idx >= 8) return 8'h00;
    if (idx & 1) v = ((m_bc[ch] << s) - m_prg[s][ch]) & mask;
    else         v = m_cur[s][ch];
    return 8'((v >> (s + (m_ptr ? 8 : 0))) & 8'hff);
  endfunction

  task automatic drive(bit w, bit r, int idx, int data, bit clr,
                       bit stp, int sch, bit dn, string tag);
    int  ch;
    bit  rel;
    exp_t e;
    @(posedge clk); #1;
    port_wr = w; port_rd = r; ptr_clear = clr;
    ofs0 = 4'(idx); ofs1 = {4'(idx), 1'b1};
    wdata = 8'(data);
    step_valid = stp; step_chan = 2'(sch); step_down = dn;
    if (r) begin
      e.e0 = exp_byte(0, idx); e.e1 = exp_byte(1, idx); e.tag = tag;
      exp_q.push_back(e);
    end
    ch = (idx >> 1) & 3;
    rel = 0;
    if (w && idx < 8) begin
      if (idx & 1) m_bc[ch] = m_ptr ? ((m_bc[ch] & 8'hff) | ((data & 8'hff) << 8))
                                    : ((m_bc[ch] & 16'hff00) | (data & 8'hff));
      else         m_ba[ch] = m_ptr ? ((m_ba[ch] & 8'hff) | ((data & 8'hff) << 8))
                                    : ((m_ba[ch] & 16'hff00) | (data & 8'hff));
      if (m_ptr) begin
        rel = 1;
        for (int s = 0; s < 2; s++) begin
          m_cur[s][ch] = m_ba[ch] << s;
          m_prg[s][ch] = 0;
        end
      end
    end
    if (stp && !(rel && sch == ch)) begin
      for (int s = 0; s < 2; s++) begin
        m_prg[s][sch] = (m_prg[s][sch] + (1 << s)) & ((1 << (16 + s)) - 1);
        m_cur[s][sch] = (dn ? m_cur[s][sch] - (1 << s) : m_cur[s][sch] + (1 << s))
                        & ((1 << (16 + s)) - 1);
      end
    end
    if (clr) m_ptr = 0;
    else if ((w || r) && idx < 8) m_ptr = ~m_ptr;
  endtask

  task automatic idle();        drive(0, 0, 0, 0, 0, 0, 0, 0, ""); endtask
  task automatic wr(int idx, int d); drive(1, 0, idx, d, 0, 0, 0, 0, ""); endtask
  task automatic rd(int idx, string tag); drive(0, 1, idx, 0, 0, 0, 0, 0, tag); endtask
  task automatic clr();         drive(0, 0, 0, 0, 1, 0, 0, 0, ""); endtask
  task automatic step(int ch, bit dn); drive(0, 0, 0, 0, 0, 1, ch, dn, ""); endtask
  task automatic wr16(int idx, int v); clr(); wr(idx, v & 8'hff); wr(idx, (v >> 8) & 8'hff); endtask
  task automatic rd16(int idx, string tag); clr(); rd(idx, tag); rd(idx, tag); endtask

  // Monitor: compares each read against the head of the expectation queue.
  always @(negedge clk) begin
    if (rst_n && port_rd) begin
      exp_t e;
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: read with no expectation, actual %02h/%02h expected none",
                 "queue", rdata0, rdata1);
      end else begin
        e = exp_q.pop_front();
        if (rdata0 !== e.e0 || rdata1 !== e.e1) begin
          n_bad++;
          $display("FAIL %s: actual %02h/%02h expected %02h/%02h",
                   e.tag, rdata0, rdata1, e.e0, e.e1);
        end
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_ba[c] = 0; m_bc[c] = 0;
      for (int s = 0; s < 2; s++) begin m_cur[s][c] = 0; m_prg[s][c] = 0; end
    end
    m_ptr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) idle();

    // R1: reset state on every channel register
    for (int i = 0; i < 8; i++) begin rd(i, "R1"); rd(i, "R1"); end

    // R5 R6: restart loads the live address; R7 count read
    wr16(0, 16'h1234);
    rd16(0, "R6_addr_after_restart");
    wr16(1, 16'h0010);
    rd16(1, "R7_count_full");

    // R8: three upward steps on channel 0
    step(0, 0); step(0, 0); step(0, 0);
    rd16(0, "R8_addr_after_steps");
    rd16(1, "R7_count_after_steps");

    // R4: low-byte write does not reload
    clr(); wr(0, 8'h99);
    rd(0, "R4_high_lane_kept");
    rd(0, "R4_low_lane_kept");

    // R3: pointer clear and clear overriding an access
    clr(); rd(0, "R3_low_first");
    clr(); rd(0, "R3_low_after_clear");
    drive(0, 1, 0, 0, 1, 0, 0, 0, "R3_clear_with_read");
    rd(0, "R3_clear_won");

    // R2: upper half of the index window is ignored
    clr(); rd(0, "R2_before_ignored");
    wr(8, 8'hAA); wr(13, 8'h55); rd(15, "R2_ignored_read");
    rd(0, "R2_ptr_not_moved");
    rd16(0, "R2_addr_unchanged");

    // R10: downward wrap from zero
    wr16(4, 16'h0000);
    step(2, 1);
    rd16(4, "R10_wrap_down");
    wr16(4, 16'hFFFF);
    step(2, 0);
    rd16(4, "R10_wrap_up");

    // R9: restart beats a step on the same channel, other channel still steps
    wr16(6, 16'h0100);
    clr(); wr(4, 8'h00);
    drive(1, 0, 4, 8'h50, 0, 1, 2, 0, "");
    rd16(4, "R9_restart_wins");
    clr(); wr(4, 8'h00);
    drive(1, 0, 4, 8'h60, 0, 1, 3, 0, "");
    rd16(4, "R9_restart_this");
    rd16(6, "R9_other_stepped");

    // R2: each channel and register decoded distinctly
    for (int c = 0; c < 4; c++) begin
      wr16(2*c,   16'hA000 + c * 16'h0111);
      wr16(2*c+1, 16'h0300 + c);
    end
    for (int c = 0; c < 4; c++) begin
      rd16(2*c,   "R2_decode_addr");
      rd16(2*c+1, "R2_decode_count");
    end

    // R7: count below zero after more steps than programmed
    wr16(3, 16'h0001);
    step(1, 0); step(1, 0);
    rd16(3, "R7_count_wraps");

    idle(); idle();
    done = 1;
    summary();
  end
endmodule